// File: doc/BRIEF.md
# Block Transfer DMA Engine

This engine moves a run of words between a single peripheral data port and memory, so the processor does not have to carry out one load and one store for every word. Software sets up a memory start address, a word count and a direction through a four-entry register window. It then writes a start command. The engine raises a bus request and waits for the arbiter's grant. After the grant it drives the memory address and the read or write strobe. It also runs a ready/acknowledge handshake with the peripheral for every word.

Every word passes through one holding register. In the device-to-memory direction, the word is latched only in the cycle where the peripheral reports ready, and the memory write follows from that register. In the other direction, a word read from memory waits in the register until the peripheral is ready to take it. When the last word has moved, the engine drops its bus request and raises a level interrupt. The interrupt stays up until software acknowledges it.

Top module: `dma_engine`

## Requirements
- R1: Register window: offset 0 holds the memory start address, offset 1 the word count, offset 2 is the command register (bit 0 direction, 1 = memory to device, 0 = device to memory; bit 1 = start), offset 3 is status. Offsets 0 and 1 read back the value last written.
- R2: After reset, and after any number of configuration writes without the start bit, busReq stays low and no memory strobe or device acknowledge is issued.
- R3: memRd, memWr and devAck are only asserted while busGnt is high, and the engine holds busReq for the whole transfer.
- R4: Device to memory: a word is latched from devRData in the cycle that devRdy is high, with devAck high in that same cycle. That word is then written with memWr held until memAck. No write happens before the device has reported ready.
- R5: Memory to device: memRd is held until memAck, the word read is presented on devWData, and it is handed over in the first cycle devRdy is high, with devAck high in that cycle.
- R6: The first word uses the start address, each following word uses the previous address plus one, and exactly the programmed count of words is moved.
- R7: After the last word, busReq is low and the busy bit clears. The done bit and irq are high from the cycle after the final handshake.
- R8: Status reads bit 0 as busy and bit 1 as done. Done and irq stay set until software writes offset 3 with bit 1 = 1. A write to offset 3 with bit 1 = 0 leaves them set.
- R9: A start command written while busy is ignored. Configuration writes during a transfer do not change the addresses or the number of words of that transfer.
- R10: A start with a count of zero sets done and irq in the next cycle without ever raising busReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | AW | Register write data |
| regRdData | output | AW | Register read data for regAddr |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant from the arbiter |
| memAddr | output | AW | Memory word address |
| memRd | output | 1 | Memory read strobe, held until memAck |
| memWr | output | 1 | Memory write strobe, held until memAck |
| memWData | output | DW | Memory write data |
| memRData | input | DW | Memory read data, valid with memAck |
| memAck | input | 1 | Memory completes the strobed access |
| devRdy | input | 1 | Peripheral has a word / can take a word |
| devAck | output | 1 | Word handed over in this cycle |
| devWData | output | DW | Word offered to the peripheral |
| devRData | input | DW | Word supplied by the peripheral |
| irq | output | 1 | Completion interrupt, level |

## Verification
Block moves run in both directions with three kinds of traffic. A peripheral that is always ready with an immediate grant shows the shortest per-word cadence. A peripheral that stalls at pseudo-random cycles with a delayed grant shows whether the holding register keeps each word until both sides complete, and whether any strobe leaks out before the grant. Every memory write and every word delivered to the device is checked against a queue of expected (address, data) pairs. A count of zero, and a restart attempt with new configuration in the middle of a transfer, show that exactly the originally programmed words move and nothing else. The interrupt is watched across idle cycles and across a status write with the acknowledge bit clear, and it must fall only on a true acknowledge.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_DEV_IN,
    ST_MEM_PUT,
    ST_MEM_GET,
    ST_DEV_OUT
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWork;    // copy programmed setup into working counters
    logic takeDev;     // latch the peripheral word
    logic takeMem;     // latch the memory word
    logic step;        // one word finished: address up, count down
    logic raiseDone;   // transfer complete
  } dmaStrobe_t;

  localparam logic [1:0] REG_ADDR  = 2'd0;
  localparam logic [1:0] REG_COUNT = 2'd1;
  localparam logic [1:0] REG_CMD   = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  localparam int CMD_DIR_BIT   = 0;
  localparam int CMD_GO_BIT    = 1;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       goBit,
  input  logic       cfgCountZero,
  input  logic       workToDev,
  input  logic       workLast,
  input  logic       busGnt,
  input  logic       devRdy,
  input  logic       memAck,
  output dmaStrobe_t stb,
  output logic       busy,
  output logic       busReq,
  output logic       memRd,
  output logic       memWr,
  output logic       devAck
);

  dmaState_t state, stateNxt;
  logic      startCmd;

  assign startCmd = regWrEn && (regAddr == REG_CMD) && goBit;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    busReq   = 1'b0;
    memRd    = 1'b0;
    memWr    = 1'b0;
    devAck   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startCmd) begin
          if (cfgCountZero) begin
            stb.raiseDone = 1'b1;
          end else begin
            stb.loadWork = 1'b1;
            stateNxt     = ST_ARB;
          end
        end
      end
      ST_ARB: begin
        busReq = 1'b1;
        if (busGnt) stateNxt = workToDev ? ST_MEM_GET : ST_DEV_IN;
      end
      ST_DEV_IN: begin
        busReq = 1'b1;
        if (devRdy) begin
          devAck      = 1'b1;
          stb.takeDev = 1'b1;
          stateNxt    = ST_MEM_PUT;
        end
      end
      ST_MEM_PUT: begin
        busReq = 1'b1;
        memWr  = 1'b1;
        if (memAck) begin
          stb.step = 1'b1;
          if (workLast) begin
            stb.raiseDone = 1'b1;
            stateNxt      = ST_IDLE;
          end else begin
            stateNxt = ST_DEV_IN;
          end
        end
      end
      ST_MEM_GET: begin
        busReq = 1'b1;
        memRd  = 1'b1;
        if (memAck) begin
          stb.takeMem = 1'b1;
          stateNxt    = ST_DEV_OUT;
        end
      end
      ST_DEV_OUT: begin
        busReq = 1'b1;
        if (devRdy) begin
          devAck   = 1'b1;
          stb.step = 1'b1;
          if (workLast) begin
            stb.raiseDone = 1'b1;
            stateNxt      = ST_IDLE;
          end else begin
            stateNxt = ST_MEM_GET;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dma_dpath.sv
module dma_dpath
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regAddr,
  input  logic [AW-1:0] regWrData,
  input  dmaStrobe_t    stb,
  input  logic          busy,
  input  logic [DW-1:0] devRData,
  input  logic [DW-1:0] memRData,
  output logic          cfgCountZero,
  output logic          workToDev,
  output logic          workLast,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] holdData,
  output logic          done,
  output logic [AW-1:0] regRdData
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] cfgAddr, cfgCount;
  logic [AW-1:0] workAddr, workCount;
  logic          ackDone;

  assign ackDone = regWrEn && (regAddr == REG_STAT) && regWrData[STAT_DONE_BIT];

  // programmed setup, always writable; a transfer runs from its own copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr  <= '0;
      cfgCount <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_ADDR)  cfgAddr  <= regWrData;
      if (regAddr == REG_COUNT) cfgCount <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workAddr  <= '0;
      workCount <= '0;
      workToDev <= 1'b0;
    end else if (stb.loadWork) begin
      workAddr  <= cfgAddr;
      workCount <= cfgCount;
      workToDev <= regWrData[CMD_DIR_BIT];
    end else if (stb.step) begin
      workAddr  <= workAddr + ONE;
      workCount <= workCount - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            holdData <= '0;
    else if (stb.takeDev) holdData <= devRData;
    else if (stb.takeMem) holdData <= memRData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              done <= 1'b0;
    else if (stb.raiseDone) done <= 1'b1;
    else if (ackDone)       done <= 1'b0;
  end

  assign cfgCountZero = (cfgCount == '0);
  assign workLast     = (workCount == ONE);
  assign memAddr      = workAddr;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_ADDR:  regRdData = cfgAddr;
      REG_COUNT: regRdData = cfgCount;
      REG_CMD:   regRdData[CMD_DIR_BIT] = workToDev;
      REG_STAT: begin
        regRdData[STAT_BUSY_BIT] = busy;
        regRdData[STAT_DONE_BIT] = done;
      end
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regAddr,
  input  logic [AW-1:0] regWrData,
  output logic [AW-1:0] regRdData,
  output logic          busReq,
  input  logic          busGnt,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] memWData,
  input  logic [DW-1:0] memRData,
  input  logic          memAck,
  input  logic          devRdy,
  output logic          devAck,
  output logic [DW-1:0] devWData,
  input  logic [DW-1:0] devRData,
  output logic          irq
);

  dmaStrobe_t    stb;
  logic          busy, cfgCountZero, workToDev, workLast, done;
  logic [DW-1:0] holdData;

  dma_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .goBit        (regWrData[CMD_GO_BIT]),
    .cfgCountZero (cfgCountZero),
    .workToDev    (workToDev),
    .workLast     (workLast),
    .busGnt       (busGnt),
    .devRdy       (devRdy),
    .memAck       (memAck),
    .stb          (stb),
    .busy         (busy),
    .busReq       (busReq),
    .memRd        (memRd),
    .memWr        (memWr),
    .devAck       (devAck)
  );

  dma_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .stb          (stb),
    .busy         (busy),
    .devRData     (devRData),
    .memRData     (memRData),
    .cfgCountZero (cfgCountZero),
    .workToDev    (workToDev),
    .workLast     (workLast),
    .memAddr      (memAddr),
    .holdData     (holdData),
    .done         (done),
    .regRdData    (regRdData)
  );

  assign memWData = holdData;
  assign devWData = holdData;
  assign irq      = done;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
  import dma_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic       cmdBit,
  input logic       busy,
  input logic       busReq,
  input logic       busGnt,
  input logic       memRd,
  input logic       memWr,
  input logic       memAck,
  input logic       devRdy,
  input logic       devAck,
  input logic       irq
);

  logic startWr, ackWr;
  assign startWr = regWrEn && (regAddr == REG_CMD) && cmdBit;
  assign ackWr   = regWrEn && (regAddr == REG_STAT) && cmdBit;

  p_idle_no_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  p_drive_needs_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || devAck) |-> busGnt);

  p_strobe_under_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> busReq);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_ack_needs_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    devAck |-> devRdy);

  p_irq_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ackWr) |=> irq);

  p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startWr && !memAck && !devRdy) |=> busy);

endmodule

bind dma_engine dma_engine_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .cmdBit  (regWrData[dma_pkg::CMD_GO_BIT]),
  .busy    (busy),
  .busReq  (busReq),
  .busGnt  (busGnt),
  .memRd   (memRd),
  .memWr   (memWr),
  .memAck  (memAck),
  .devRdy  (devRdy),
  .devAck  (devAck),
  .irq     (irq)
);

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  import dma_pkg::*;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [AW-1:0] regWrData = '0;
  logic [AW-1:0] regRdData;
  logic          busReq, busGnt;
  logic [AW-1:0] memAddr;
  logic          memRd, memWr, memAck;
  logic [DW-1:0] memWData, memRData;
  logic          devRdy, devAck;
  logic [DW-1:0] devWData, devRData;
  logic          irq;

  dma_engine #(.AW(AW), .DW(DW)) dut (.*);

  initial forever #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int gntWait = 0;
  int gntCnt = 0;
  int reqCycles = 0;
  int devIdx = 0;
  bit stallOn = 1'b0;
  bit curToDev = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  localparam logic [DW-1:0] DEV_BASE = 32'hD00D_0000;

  logic [DW-1:0]      memArr [0:255];
  logic [AW+DW-1:0]   expWr[$];
  logic [DW-1:0]      expDev[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // bus models and scoreboard monitor
  initial begin
    busGnt = 1'b0; memAck = 1'b0; devRdy = 1'b0;
    devRData = '0; memRData = '0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        busGnt = 1'b0; memAck = 1'b0; gntCnt = 0;
        continue;
      end
      if (busReq) begin
        reqCycles++;
        if (gntCnt >= gntWait) busGnt = 1'b1;
        else gntCnt++;
      end else begin
        busGnt = 1'b0;
        gntCnt = 0;
      end
      if (memAck) begin
        memAck = 1'b0;
      end else if (memWr) begin
        memAck = 1'b1;
        memArr[memAddr[7:0]] = memWData;
        if (expWr.size() == 0) begin
          check(1'b0, "R6 extra memory write", 64'(memAddr), 64'hFFFF);
        end else begin
          logic [AW+DW-1:0] e;
          e = expWr.pop_front();
          check({memAddr, memWData} == e, "R4 R6 memory write addr/data", 64'({memAddr, memWData}), 64'(e));
        end
      end else if (memRd) begin
        memAck = 1'b1;
        memRData = memArr[memAddr[7:0]];
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      devRdy = stallOn ? (lfsr[1] | lfsr[3]) : 1'b1;
      devRData = DEV_BASE + DW'(devIdx);
      #1;
      if ((memRd || memWr || devAck) && !busGnt)
        check(1'b0, "R3 bus driven without grant", 64'({memRd, memWr, devAck}), 64'd0);
      if (devAck) begin
        if (curToDev) begin
          if (expDev.size() == 0) begin
            check(1'b0, "R6 extra device word", 64'(devWData), 64'hFFFF);
          end else begin
            logic [DW-1:0] d;
            d = expDev.pop_front();
            check(devWData == d, "R5 R6 device word", 64'(devWData), 64'(d));
          end
        end else begin
          devIdx++;
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // driver: program, push expectations, start
  task automatic startXfer(input int addr, input int count, input bit toDev, input int gw, input bit stall);
    gntWait = gw; stallOn = stall; curToDev = toDev;
    for (int i = 0; i < count; i++) begin
      if (toDev) expDev.push_back(memArr[(addr + i) & 255]);
      else expWr.push_back({AW'(addr + i), DEV_BASE + DW'(devIdx + i)});
    end
    regWrite(REG_ADDR, AW'(addr));
    regWrite(REG_COUNT, AW'(count));
    regWrite(REG_CMD, toDev ? AW'(3) : AW'(2));
  endtask

  task automatic finishXfer(input string tag);
    logic [AW-1:0] st;
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check(irq, {tag, " R7 completion irq"}, 64'(irq), 64'd1);
    check(expWr.size() == 0 && expDev.size() == 0, {tag, " R6 all words moved"},
          64'(expWr.size() + expDev.size()), 64'd0);
    check(!busReq, {tag, " R7 bus released"}, 64'(busReq), 64'd0);
    regRead(REG_STAT, st);
    check(st == AW'(2), {tag, " R8 status done not busy"}, 64'(st), 64'd2);
  endtask

  task automatic ackIrq(input string tag);
    regWrite(REG_STAT, AW'(2));
    #1 check(!irq, {tag, " R8 irq cleared"}, 64'(irq), 64'd0);
  endtask

  initial begin
    logic [AW-1:0] rd;
    int reqBefore;
    for (int i = 0; i < 256; i++) memArr[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0107);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!irq, "R8 reset irq low", 64'(irq), 64'd0);
    check(!busReq, "R2 reset busReq low", 64'(busReq), 64'd0);
    regRead(REG_STAT, rd);
    check(rd == '0, "R8 reset status", 64'(rd), 64'd0);

    // configuration without start
    regWrite(REG_ADDR, 16'h1234);
    regWrite(REG_COUNT, 16'h0007);
    regWrite(REG_CMD, 16'h0001);
    regRead(REG_ADDR, rd);
    check(rd == 16'h1234, "R1 address readback", 64'(rd), 64'h1234);
    regRead(REG_COUNT, rd);
    check(rd == 16'h0007, "R1 count readback", 64'(rd), 64'h7);
    repeat (10) @(negedge clk);
    check(reqCycles == 0, "R2 no request without start", 64'(reqCycles), 64'd0);

    // device to memory, delayed grant, stalling device
    startXfer(16'h10, 5, 1'b0, 3, 1'b1);
    finishXfer("R4 dev-to-mem stall");
    repeat (15) @(negedge clk);
    check(irq, "R8 irq held while idle", 64'(irq), 64'd1);
    regWrite(REG_STAT, AW'(1));
    #1 check(irq, "R8 irq kept on write without ack bit", 64'(irq), 64'd1);
    ackIrq("R8");

    // memory to device, immediate grant, ready device
    startXfer(16'h40, 6, 1'b1, 0, 1'b0);
    finishXfer("R5 mem-to-dev fast");
    ackIrq("R5");

    // memory to device with stalls
    startXfer(16'h80, 4, 1'b1, 2, 1'b1);
    finishXfer("R5 mem-to-dev stall");
    ackIrq("R5");

    // device to memory single word, ready device
    startXfer(16'hC0, 1, 1'b0, 0, 1'b0);
    finishXfer("R6 single word");
    ackIrq("R6");

    // zero count
    reqBefore = reqCycles;
    regWrite(REG_COUNT, AW'(0));
    regWrite(REG_CMD, AW'(2));
    #1 check(irq, "R10 zero count done at once", 64'(irq), 64'd1);
    repeat (5) @(negedge clk);
    check(reqCycles == reqBefore, "R10 zero count no request", 64'(reqCycles - reqBefore), 64'd0);
    ackIrq("R10");

    // restart attempt while busy
    startXfer(16'h20, 12, 1'b0, 2, 1'b1);
    repeat (4) @(negedge clk);
    regRead(REG_STAT, rd);
    check(rd[STAT_BUSY_BIT] == 1'b1, "R9 busy during transfer", 64'(rd), 64'd1);
    regWrite(REG_ADDR, 16'h90);
    regWrite(REG_COUNT, 16'h2);
    regWrite(REG_CMD, 16'h3);
    finishXfer("R9 restart ignored");
    ackIrq("R9");

    repeat (5) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired (R7 completion) actual=running expected=finished");
    summary();
  end

endmodule